// File: doc/BRIEF.md
# Vector Frequency License Controller

This block decides which of three clock-speed licenses a core runs in. License 0 is the fastest and license 2 the slowest. The decision follows the stream of retired instructions. Each cycle the block may receive one instruction, described by a valid strobe, a two-bit width code and a heavy flag. From these the block derives the license that the instruction needs. An instruction that needs a higher license than the current one raises the license in one of two ways.

A light 512-bit instruction seen in license 0 takes the hard path. The core is stalled for a fixed number of halt cycles, and then license 1 takes effect. A heavy 256-bit or 512-bit instruction that needs more than the current license takes the soft path. The license stays where it is, and a throttle output tells the issue logic to run heavy work at a quarter of its normal rate. The license is raised only once enough of these heavy instructions arrive within one measurement window. The license never drops because of a particular instruction. It drops one level at a time, after a quiet period in which no instruction needed the current level.

Top module: `vfl_license_ctrl`

## Requirements
- R1: After reset the license is 0 and stall and throttle are low; the license output never takes the value 3.
- R2: The width code is 0 for scalar, 1 for 128-bit, 2 for 256-bit and 3 for 512-bit. The required license is 0 for scalar and for all 128-bit instructions. It is 0 for a light 256-bit instruction and 1 for a heavy one. It is 1 for a light 512-bit instruction and 2 for a heavy one.
- R3: An instruction whose required license is at or below the current license changes neither the license nor stall nor throttle.
- R4: A light 512-bit instruction accepted in license 0 raises stall from the next cycle. Stall stays high for HALT_CYC cycles. The license becomes 1 in the same cycle that stall falls. Instructions presented while stall is high are ignored.
- R5: A heavy instruction that needs more than the current license, accepted while stall is low, raises throttle from the next cycle and leaves the license unchanged.
- R6: When the THRESH-th such heavy instruction arrives in a window of WIN_LEN cycles that begins at the first one, the license rises to the highest pending requirement on the next cycle and throttle falls.
- R7: If a window ends with fewer than THRESH heavy hits, the license is not raised. The pending request is dropped, unless a heavy hit arrives in the window's last cycle.
- R8: With the license above 0, the license drops by exactly one level after DOWN_CYC consecutive accepted cycles with no instruction whose requirement is at or above the current license.
- R9: A hard transition that starts while a soft request is pending is served first. If the pending requirement is 2, throttle stays high after the license reaches 1.
- R10: Soft-transition counting and the downgrade timer are frozen while stall is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | An instruction retires this cycle |
| insn_width | input | 2 | Width code: 0 scalar, 1 128-bit, 2 256-bit, 3 512-bit |
| insn_heavy | input | 1 | Instruction uses the floating-point or multiply unit |
| license | output | 2 | Current license, 0 to 2 |
| stall | output | 1 | Halt request during a hard transition |
| throttle | output | 1 | Limit heavy issue to a quarter rate |

## Verification
The hardest case to reach is a light 512-bit instruction arriving while a soft request to license 2 is still pending, with heavy instructions then pressing on through the halt cycles. The stimulus builds this case on purpose. It first issues one heavy 512-bit instruction in license 0. It then issues the light 512-bit instruction. It keeps feeding heavy instructions during the stall and checks that throttle survives the move to license 1. Sparse heavy patterns, spaced so that a window expires one short of the threshold, exercise the path where a pending request is dropped. Seeded random phases of varying density are then compared cycle by cycle against a reference model in the bench.

// File: rtl/vfl_pkg.sv
package vfl_pkg;

  typedef logic [1:0] lic_t;

  typedef enum logic [1:0] {
    WC_SCALAR = 2'd0,
    WC_128    = 2'd1,
    WC_256    = 2'd2,
    WC_512    = 2'd3
  } width_code_e;

  function automatic lic_t need_of(input width_code_e w, input logic heavy);
    lic_t r;
    case (w)
      WC_256:  r = heavy ? 2'd1 : 2'd0;
      WC_512:  r = heavy ? 2'd2 : 2'd1;
      default: r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vfl_halt_seq.sv
module vfl_halt_seq #(
  parameter int HALT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic stall,
  output logic done
);
  localparam int CW = $clog2(HALT_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HALT_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else if (start)   cnt_d = LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall = (cnt_q != '0);
  assign done  = (cnt_q == CW'(1));

  assert_halt_begins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stall) |=> stall);

  assert_halt_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stall);

endmodule

// File: rtl/vfl_soft_track.sv
module vfl_soft_track
  import vfl_pkg::*;
#(
  parameter int WIN_LEN = 64,
  parameter int THRESH  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  lic_t req,
  input  lic_t lic,
  input  lic_t lic_nxt,
  input  logic chg,
  output logic raise,
  output lic_t tgt,
  output logic throttle
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int HW = $clog2(THRESH + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [HW:0]   THR_V    = (HW+1)'(THRESH);

  logic [WW-1:0] win_q, win_d;
  logic [HW-1:0] hv_q, hv_d;
  lic_t          pend_q, pend_d, pend_n;
  logic [HW:0]   sum;

  always_comb begin
    pend_n = (hit && (req > pend_q)) ? req : pend_q;
    sum    = {1'b0, hv_q} + {{HW{1'b0}}, hit};
    raise  = en && (pend_n > lic) && (sum >= THR_V);
    tgt    = pend_n;
  end

  always_comb begin
    win_d  = win_q;
    hv_d   = hv_q;
    pend_d = pend_q;
    if (chg) begin
      win_d  = '0;
      hv_d   = '0;
      pend_d = (pend_n > lic_nxt) ? pend_n : 2'd0;
    end else if (en) begin
      if (pend_n > lic) begin
        if (win_q == WIN_LAST) begin
          win_d  = '0;
          hv_d   = '0;
          pend_d = hit ? pend_n : 2'd0;
        end else begin
          win_d  = win_q + 1'b1;
          hv_d   = sum[HW-1:0];
          pend_d = pend_n;
        end
      end else begin
        win_d  = '0;
        hv_d   = '0;
        pend_d = 2'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      hv_q   <= '0;
      pend_q <= 2'd0;
    end else begin
      win_q  <= win_d;
      hv_q   <= hv_d;
      pend_q <= pend_d;
    end
  end

  assign throttle = (pend_q > lic);

  assert_hits_below_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, hv_q} < THR_V);

  assert_frozen_in_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !chg) |=> ($stable(hv_q) && $stable(win_q)));

endmodule

// File: rtl/vfl_quiet_timer.sv
module vfl_quiet_timer
  import vfl_pkg::*;
#(
  parameter int DOWN_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic refresh,
  input  lic_t lic,
  input  logic chg,
  output logic expire
);
  localparam int QW = $clog2(DOWN_CYC);
  localparam logic [QW-1:0] Q_LAST = QW'(DOWN_CYC - 1);

  logic [QW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (chg || (lic == 2'd0)) cnt_d = '0;
    else if (en) begin
      if (refresh) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = en && (lic != 2'd0) && !refresh && (cnt_q == Q_LAST);

  assert_timer_idle_at_l0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lic == 2'd0) |=> (cnt_q == '0));

endmodule

// File: rtl/vfl_license_ctrl.sv
module vfl_license_ctrl
  import vfl_pkg::*;
#(
  parameter int HALT_CYC = 8,
  parameter int WIN_LEN  = 64,
  parameter int THRESH   = 16,
  parameter int DOWN_CYC = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       insn_valid,
  input  logic [1:0] insn_width,
  input  logic       insn_heavy,
  output logic [1:0] license,
  output logic       stall,
  output logic       throttle
);
  lic_t lic_q, lic_d, req, tgt;
  logic acc, hit, refresh, start, done, raise, expire, chg;

  always_comb begin
    req     = need_of(width_code_e'(insn_width), insn_heavy);
    acc     = insn_valid && !stall;
    hit     = acc && insn_heavy && (req > lic_q);
    refresh = acc && (req >= lic_q);
    start   = acc && (width_code_e'(insn_width) == WC_512) && !insn_heavy
              && (lic_q == 2'd0);
  end

  vfl_halt_seq #(.HALT_CYC(HALT_CYC)) u_halt (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .stall (stall),
    .done  (done)
  );

  vfl_soft_track #(.WIN_LEN(WIN_LEN), .THRESH(THRESH)) u_soft (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (!stall),
    .hit      (hit),
    .req      (req),
    .lic      (lic_q),
    .lic_nxt  (lic_d),
    .chg      (chg),
    .raise    (raise),
    .tgt      (tgt),
    .throttle (throttle)
  );

  vfl_quiet_timer #(.DOWN_CYC(DOWN_CYC)) u_quiet (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (!stall),
    .refresh (refresh),
    .lic     (lic_q),
    .chg     (chg),
    .expire  (expire)
  );

  always_comb begin
    lic_d = lic_q;
    if (done)        lic_d = 2'd1;
    else if (raise)  lic_d = tgt;
    else if (expire) lic_d = lic_q - 2'd1;
    chg = (lic_d != lic_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lic_q <= 2'd0;
    else        lic_q <= lic_d;
  end

  assign license = lic_q;

  assert_license_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    license != 2'd3);

  assert_halt_only_from_l0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (license == 2'd0));

  assert_halt_lands_l1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (license == 2'd1));

  assert_drop_one_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (license < $past(license)) |-> (($past(license) - license) == 2'd1));

endmodule

// File: tb/vfl_license_ctrl_tb_top.sv
module vfl_license_ctrl_tb_top;
  localparam int HALT = 4;
  localparam int WIN  = 16;
  localparam int THR  = 4;
  localparam int DOWN = 40;

  logic clk, rst_n, v, hv;
  logic [1:0] w;
  logic [1:0] license;
  logic stall, throttle;

  int checks = 0, fails = 0, cyc = 0;
  string cur_tag = "R1";
  bit done_run = 0;

  vfl_license_ctrl #(.HALT_CYC(HALT), .WIN_LEN(WIN), .THRESH(THR), .DOWN_CYC(DOWN)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_valid(v), .insn_width(w), .insn_heavy(hv),
    .license(license), .stall(stall), .throttle(throttle)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // reference model state
  int m_lic, m_halt, m_win, m_hv, m_pend, m_quiet;

  function automatic int need(input logic [1:0] wc, input logic h);
    if (wc == 2'd2) return h ? 1 : 0;
    if (wc == 2'd3) return h ? 2 : 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lic = 0; m_halt = 0; m_win = 0; m_hv = 0; m_pend = 0; m_quiet = 0;
    end else begin
      int req, pn, nl;
      bit st, acc, hit, rf, dn, sta, rs, ex, ch;
      st  = (m_halt != 0);
      acc = v && !st;
      req = need(w, hv);
      hit = acc && hv && (req > m_lic);
      rf  = acc && (req >= m_lic);
      dn  = (m_halt == 1);
      sta = acc && (w == 2'd3) && !hv && (m_lic == 0);
      pn  = (hit && req > m_pend) ? req : m_pend;
      rs  = !st && (pn > m_lic) && (m_hv + int'(hit) >= THR);
      ex  = !st && (m_lic > 0) && !rf && (m_quiet == DOWN - 1);
      nl  = dn ? 1 : rs ? pn : ex ? m_lic - 1 : m_lic;
      ch  = (nl != m_lic);
      if (ch) begin
        m_win = 0; m_hv = 0; m_pend = (pn > nl) ? pn : 0;
      end else if (!st) begin
        if (pn > m_lic) begin
          if (m_win == WIN - 1) begin m_win = 0; m_hv = 0; m_pend = hit ? pn : 0; end
          else begin m_win++; m_hv += int'(hit); m_pend = pn; end
        end else begin m_win = 0; m_hv = 0; m_pend = 0; end
      end
      if (ch || m_lic == 0) m_quiet = 0;
      else if (!st) m_quiet = rf ? 0 : m_quiet + 1;
      m_halt = st ? m_halt - 1 : (sta ? HALT : 0);
      m_lic = nl;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic cmp_model();
    chk(cur_tag, license, m_lic, "license");
    chk(cur_tag, stall, int'(m_halt != 0), "stall");
    chk(cur_tag, throttle, int'(m_pend > m_lic), "throttle");
  endtask

  // drive at negedge, advance one edge, compare against model
  task automatic step(input logic vv, input logic [1:0] ww, input logic hh);
    v = vv; w = ww; hv = hh;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'd0, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done_run) begin
      done_run = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    v = 0; w = 0; hv = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1", license, 0, "license in reset");
    chk("R1", stall, 0, "stall in reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1", license, 0, "license after reset");
    chk("R1", throttle, 0, "throttle after reset");

    // R3/R2: low-need instructions at license 0
    cur_tag = "R3";
    step(1, 2'd2, 0); step(1, 2'd1, 1); step(1, 2'd0, 0);
    chk("R3", license, 0, "light 256 keeps L0");
    chk("R3", throttle, 0, "heavy 128 no throttle");

    // R4: hard transition timing
    cur_tag = "R4";
    step(1, 2'd3, 0);
    chk("R4", stall, 1, "stall after light 512");
    chk("R4", license, 0, "license held during halt");
    for (int i = 0; i < HALT - 1; i++) begin
      step(1, 2'd3, 1);
      chk("R4", stall, 1, "stall held");
    end
    step(0, 2'd0, 0);
    chk("R4", stall, 0, "stall released");
    chk("R4", license, 1, "license 1 after halt");
    chk("R10", throttle, 0, "heavies during halt ignored");

    // R2/R3 at license 1
    cur_tag = "R2";
    step(1, 2'd2, 1);
    chk("R2", license, 1, "heavy 256 needs L1");
    chk("R2", throttle, 0, "heavy 256 no throttle at L1");

    // R5/R6 soft transition to 2
    cur_tag = "R5";
    step(1, 2'd3, 1);
    chk("R5", throttle, 1, "throttle after heavy 512");
    chk("R5", license, 1, "license unchanged");
    cur_tag = "R6";
    step(1, 2'd3, 1); step(1, 2'd3, 1);
    chk("R6", license, 1, "below threshold");
    step(1, 2'd3, 1);
    chk("R6", license, 2, "raised at threshold");
    chk("R6", throttle, 0, "throttle cleared");

    // R8 downgrade
    cur_tag = "R8";
    idle(DOWN - 1);
    chk("R8", license, 2, "held before timeout");
    step(0, 2'd0, 0);
    chk("R8", license, 1, "dropped one level");

    // R7 sparse heavies never raise
    cur_tag = "R7";
    for (int k = 0; k < 10; k++) begin
      step(1, 2'd3, 1);
      idle(5);
    end
    chk("R7", license, 1, "sparse heavies no raise");

    // R9 hard during pending soft
    cur_tag = "R8";
    idle(DOWN + 2);
    chk("R8", license, 0, "back to L0");
    cur_tag = "R9";
    step(1, 2'd3, 1);
    chk("R9", throttle, 1, "soft pending");
    step(1, 2'd3, 0);
    chk("R9", stall, 1, "hard served first");
    for (int i = 0; i < HALT; i++) step(1, 2'd3, 1);
    chk("R9", license, 1, "hard lands on L1");
    chk("R9", throttle, 1, "soft to L2 still pending");

    // seeded random phases
    cur_tag = "R2";
    idle(2 * DOWN + 4);
    for (int p = 0; p < 24; p++) begin
      int dens;
      dens = $urandom_range(1, 100);
      for (int i = 0; i < 150; i++) begin
        logic rv, rh;
        logic [1:0] rw;
        rv = ($urandom_range(1, 100) <= dens);
        rw = 2'($urandom_range(0, 3));
        rh = ($urandom_range(0, 2) != 0);
        step(rv, rw, rh);
      end
      if (p % 6 == 5) idle(3 * DOWN);
    end

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule